// File: doc/BRIEF.md
# Prioritized Input Clock Selector

This block decides which of two reference inputs feeds a downstream synthesis loop. Each input reports raw alarms: a normal loss-of-signal detector, a slower, less sensitive loss-of-signal detector, and a frequency-offset detector. A per-input enable field chooses which loss-of-signal detector counts, or turns monitoring off. Once an input has been alarm-free for a programmable number of cycles, it is treated as qualified. The selection policy then works from the qualified inputs.

There are three policies. In manual mode the choice comes from an external select pin or from a register field. In automatic non-revertive mode the selector stays on its input while that input is good. In automatic revertive mode it always moves to the best qualified input named in a two-entry priority table. When no eligible input is qualified in an automatic mode, the selector raises a hold flag and keeps its last choice.

The outputs are the selected index, a one-hot active status, and an active-clock pin whose polarity is programmable. Each input also has a bad-status pin with a shared programmable polarity; that pin is released to high impedance when it is not enabled.

Top module: `csel_top`

## Requirements
- R1: An input is raw-bad in any cycle where its frequency-offset alarm is high. It is also raw-bad when its loss-of-signal enable is 2'b11 and the normal detector is high, or when the enable is 2'b10 and the slow detector is high. Enable codes 2'b00 and 2'b01 ignore both loss-of-signal detectors.
- R2: A raw-bad sample makes the input unqualified after the next clock edge. The input becomes qualified on the edge that takes its (validTime+1)-th consecutive raw-good sample. After reset both inputs are unqualified.
- R3: badPin[i] shows "input i unqualified". When badPol=1 the pin is driven high for unqualified; when badPol=0 it is driven low for unqualified. When badPinEn[i]=0 the pin is high impedance.
- R4: In mode 2'b00 (manual), the edge after the inputs are sampled selects selPin when pinCtrl=1 (0 = input 1, 1 = input 2). When pinCtrl=0, regSel chooses instead: 2'b00 is input 1 and 2'b01 is input 2, and codes 2'b1x keep the current choice.
- R5: pinCtrl and selPin have no effect in any mode other than manual.
- R6: In mode 2'b01 (non-revertive), the selector keeps its input while that input is eligible and qualified. Otherwise it moves to the other input if that input is eligible and qualified, and otherwise it keeps its input.
- R7: In mode 2'b10 (revertive), the selector picks the input named by prioFirst if that input is qualified, else the one named by prioSecond if qualified, else keeps its input. Priority codes are 2'b00 = input 1, 2'b01 = input 2; codes 2'b1x name no input.
- R8: An input named by neither priority field is never chosen by an automatic mode.
- R9: In an automatic mode, holdFlag is 1 after an edge where no input is both eligible and qualified, and it is 0 otherwise. Manual mode clears holdFlag, and while holdFlag is 1 the selection does not change.
- R10: Mode 2'b11 keeps both the selection and holdFlag unchanged.
- R11: activeStat is one-hot, with bit 0 meaning input 1 and bit 1 meaning input 2. activePin is high when input 2 is active if actPol=1, and low when input 2 is active if actPol=0.
- R12: During reset, selIdx=0, activeStat=2'b01 and holdFlag=0, and both inputs are unqualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| losNormal | input | 2 | Normal loss-of-signal detector per input |
| losSlow | input | 2 | Slow loss-of-signal detector per input |
| fosAlarm | input | 2 | Frequency-offset alarm per input |
| losEn1 | input | 2 | Loss-of-signal enable, input 1 |
| losEn2 | input | 2 | Loss-of-signal enable, input 2 |
| selMode | input | 2 | Selection policy |
| prioFirst | input | 2 | First-priority input code |
| prioSecond | input | 2 | Second-priority input code |
| pinCtrl | input | 1 | Manual source: 1 pin, 0 register |
| selPin | input | 1 | External manual select |
| regSel | input | 2 | Register manual select |
| validTime | input | VT_W | Qualification interval in cycles |
| actPol | input | 1 | Active-clock pin polarity |
| badPol | input | 1 | Bad-status pin polarity |
| badPinEn | input | 2 | Bad-status pin drive enable per input |
| selIdx | output | 1 | Selected input (0 = input 1) |
| activeStat | output | 2 | One-hot active input |
| activePin | output | 1 | Active-clock indicator pin |
| holdFlag | output | 1 | No eligible qualified input |
| badPin | output | 2 | Bad-status pins, tristate |

## Verification
The hardest states to reach are the revertive return after a fault, the non-revertive refusal to return, and hold entered while one input is qualified but not named in the priority table. Reaching them needs alarms that persist long enough to pass the qualification counter, and they must fall on the right input while the priority fields point the right way. The stimulus therefore sets the alarm lines to rare, sticky toggles under configurations that are held for a whole phase. Directed phases put one input out of the priority table and drive its partner into alarm. A cycle-level reference model in the bench predicts every output throughout.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int NUM_IN = 2;

  typedef enum logic [1:0] {
    MODE_MANUAL = 2'b00,
    MODE_NONREV = 2'b01,
    MODE_REV    = 2'b10,
    MODE_RSVD   = 2'b11
  } selMode_e;

  localparam logic [1:0] CODE_IN1 = 2'b00;
  localparam logic [1:0] CODE_IN2 = 2'b01;
  localparam logic [1:0] LOS_SLOW = 2'b10;
  localparam logic [1:0] LOS_NORM = 2'b11;

  // strobes from the policy control to the datapath
  typedef struct packed {
    logic useTwo;
    logic hold;
  } selStrobe_t;
endpackage

// File: rtl/csel_qual.sv
module csel_qual
  import csel_pkg::*;
#(
  parameter int VT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      losEn,
  input  logic            losNormal,
  input  logic            losSlow,
  input  logic            fosAlarm,
  input  logic [VT_W-1:0] validTime,
  output logic            qualOk
);
  logic            rawBad;
  logic [VT_W-1:0] cleanCnt;

  always_comb begin
    rawBad = fosAlarm;
    if (losEn == LOS_NORM) rawBad = rawBad | losNormal;
    if (losEn == LOS_SLOW) rawBad = rawBad | losSlow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cleanCnt <= '0;
      qualOk   <= 1'b0;
    end else if (rawBad) begin
      cleanCnt <= '0;
      qualOk   <= 1'b0;
    end else if (cleanCnt < validTime) begin
      cleanCnt <= cleanCnt + 1'b1;
    end else begin
      qualOk   <= 1'b1;
    end
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int VT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] losNormal,
  input  logic [NUM_IN-1:0] losSlow,
  input  logic [NUM_IN-1:0] fosAlarm,
  input  logic [2*NUM_IN-1:0] losEnAll,
  input  logic [VT_W-1:0]   validTime,
  input  logic              actPol,
  input  logic              badPol,
  input  logic [NUM_IN-1:0] badPinEn,
  input  selStrobe_t        strobe,
  output logic [NUM_IN-1:0] qualOk,
  output logic              selIdx,
  output logic [NUM_IN-1:0] activeStat,
  output logic              activePin,
  output logic              holdFlag,
  output logic [NUM_IN-1:0] badPin
);
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    csel_qual #(.VT_W(VT_W)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .losEn    (losEnAll[2*gi +: 2]),
      .losNormal(losNormal[gi]),
      .losSlow  (losSlow[gi]),
      .fosAlarm (fosAlarm[gi]),
      .validTime(validTime),
      .qualOk   (qualOk[gi])
    );
    assign badPin[gi] = badPinEn[gi] ? (badPol ? ~qualOk[gi] : qualOk[gi]) : 1'bz;
  end

  assign selIdx     = strobe.useTwo;
  assign holdFlag   = strobe.hold;
  assign activeStat = strobe.useTwo ? 2'b10 : 2'b01;
  assign activePin  = actPol ? strobe.useTwo : ~strobe.useTwo;
endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        selMode,
  input  logic [1:0]        prioFirst,
  input  logic [1:0]        prioSecond,
  input  logic              pinCtrl,
  input  logic              selPin,
  input  logic [1:0]        regSel,
  input  logic [NUM_IN-1:0] qualOk,
  output selStrobe_t        strobe
);
  selStrobe_t          nxt;
  logic [NUM_IN-1:0]   elig;
  logic [NUM_IN-1:0]   good;
  selMode_e            mode;

  assign mode    = selMode_e'(selMode);
  assign elig[0] = (prioFirst == CODE_IN1) | (prioSecond == CODE_IN1);
  assign elig[1] = (prioFirst == CODE_IN2) | (prioSecond == CODE_IN2);
  assign good    = elig & qualOk;

  always_comb begin
    nxt = strobe;
    unique case (mode)
      MODE_MANUAL: begin
        nxt.hold = 1'b0;
        if (pinCtrl)                 nxt.useTwo = selPin;
        else if (regSel == CODE_IN1) nxt.useTwo = 1'b0;
        else if (regSel == CODE_IN2) nxt.useTwo = 1'b1;
      end
      MODE_NONREV: begin
        nxt.hold = (good == '0);
        if (!good[strobe.useTwo] && good[~strobe.useTwo])
          nxt.useTwo = ~strobe.useTwo;
      end
      MODE_REV: begin
        nxt.hold = (good == '0);
        if (prioFirst == CODE_IN1 && good[0])       nxt.useTwo = 1'b0;
        else if (prioFirst == CODE_IN2 && good[1])  nxt.useTwo = 1'b1;
        else if (prioSecond == CODE_IN1 && good[0]) nxt.useTwo = 1'b0;
        else if (prioSecond == CODE_IN2 && good[1]) nxt.useTwo = 1'b1;
      end
      default: nxt = strobe;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= nxt;
  end
endmodule

// File: rtl/csel_top.sv
module csel_top
  import csel_pkg::*;
#(
  parameter int VT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      losNormal,
  input  logic [1:0]      losSlow,
  input  logic [1:0]      fosAlarm,
  input  logic [1:0]      losEn1,
  input  logic [1:0]      losEn2,
  input  logic [1:0]      selMode,
  input  logic [1:0]      prioFirst,
  input  logic [1:0]      prioSecond,
  input  logic            pinCtrl,
  input  logic            selPin,
  input  logic [1:0]      regSel,
  input  logic [VT_W-1:0] validTime,
  input  logic            actPol,
  input  logic            badPol,
  input  logic [1:0]      badPinEn,
  output logic            selIdx,
  output logic [1:0]      activeStat,
  output logic            activePin,
  output logic            holdFlag,
  output wire  [1:0]      badPin
);
  selStrobe_t        strobe;
  logic [NUM_IN-1:0] qualOk;

  csel_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .selMode(selMode), .prioFirst(prioFirst),
    .prioSecond(prioSecond), .pinCtrl(pinCtrl), .selPin(selPin),
    .regSel(regSel), .qualOk(qualOk), .strobe(strobe)
  );

  csel_datapath #(.VT_W(VT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .losNormal(losNormal), .losSlow(losSlow),
    .fosAlarm(fosAlarm), .losEnAll({losEn2, losEn1}), .validTime(validTime),
    .actPol(actPol), .badPol(badPol), .badPinEn(badPinEn), .strobe(strobe),
    .qualOk(qualOk), .selIdx(selIdx), .activeStat(activeStat),
    .activePin(activePin), .holdFlag(holdFlag), .badPin(badPin)
  );
endmodule

// File: rtl/csel_chk.sv
module csel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fosAlarm,
  input logic [1:0] selMode,
  input logic       pinCtrl,
  input logic       selPin,
  input logic       actPol,
  input logic       badPol,
  input logic [1:0] badPinEn,
  input logic       selIdx,
  input logic [1:0] activeStat,
  input logic       activePin,
  input logic       holdFlag,
  input wire  [1:0] badPin
);
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(activeStat) == 1);

  a_r11_pin_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    activePin == (actPol ? activeStat[1] : activeStat[0]));

  a_r4_pin_select: assert property (@(posedge clk) disable iff (!rst_n)
    (selMode == 2'b00 && pinCtrl) |=> selIdx == $past(selPin));

  a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    holdFlag |-> $stable(selIdx));

  a_r9_manual_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (selMode == 2'b00) |=> !holdFlag);

  a_r1_fos_bad_in1: assert property (@(posedge clk) disable iff (!rst_n)
    fosAlarm[0] |=> (!badPinEn[0] || badPin[0] == badPol));

  a_r1_fos_bad_in2: assert property (@(posedge clk) disable iff (!rst_n)
    fosAlarm[1] |=> (!badPinEn[1] || badPin[1] == badPol));
endmodule

bind csel_top csel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fosAlarm(fosAlarm), .selMode(selMode),
  .pinCtrl(pinCtrl), .selPin(selPin), .actPol(actPol), .badPol(badPol),
  .badPinEn(badPinEn), .selIdx(selIdx), .activeStat(activeStat),
  .activePin(activePin), .holdFlag(holdFlag), .badPin(badPin)
);

// File: tb/csel_top_bench.sv
module csel_top_bench;
  localparam int VT_W = 8;
  logic clk = 0, rst_n = 0;
  logic [1:0] losNormal = 0, losSlow = 0, fosAlarm = 0, losEn1 = 2'b11, losEn2 = 2'b11;
  logic [1:0] selMode = 0, prioFirst = 0, prioSecond = 2'b01, regSel = 0, badPinEn = 2'b11;
  logic pinCtrl = 0, selPin = 0, actPol = 1, badPol = 1;
  logic [VT_W-1:0] validTime = 3;
  logic selIdx, activePin, holdFlag;
  logic [1:0] activeStat;
  wire badA, badB;
  pulldown (badA);
  pulldown (badB);

  int nRun = 0, nFail = 0;
  bit done = 0;
  string curTag = "R12";

  always #10 clk = ~clk;

  csel_top #(.VT_W(VT_W)) u_csel_top (
    .clk(clk), .rst_n(rst_n), .losNormal(losNormal), .losSlow(losSlow),
    .fosAlarm(fosAlarm), .losEn1(losEn1), .losEn2(losEn2), .selMode(selMode),
    .prioFirst(prioFirst), .prioSecond(prioSecond), .pinCtrl(pinCtrl),
    .selPin(selPin), .regSel(regSel), .validTime(validTime), .actPol(actPol),
    .badPol(badPol), .badPinEn(badPinEn), .selIdx(selIdx),
    .activeStat(activeStat), .activePin(activePin), .holdFlag(holdFlag),
    .badPin({badB, badA})
  );

  // reference model built from the requirements
  logic [VT_W-1:0] mCnt [2];
  logic [1:0] mQual;
  logic mSel, mHold;

  function automatic logic fRawBad(logic [1:0] en, logic n, logic s, logic f); // R1
    return f | (en == 2'b11 && n) | (en == 2'b10 && s);
  endfunction

  function automatic logic fNames(logic [1:0] code, int idx);
    return code == 2'(idx);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt[0] <= 0; mCnt[1] <= 0; mQual <= 0; mSel <= 0; mHold <= 0;
    end else begin
      logic [1:0] good;
      logic ns, nh;
      for (int i = 0; i < 2; i++) begin
        if (fRawBad(i == 0 ? losEn1 : losEn2, losNormal[i], losSlow[i], fosAlarm[i])) begin
          mCnt[i] <= 0; mQual[i] <= 0;
        end else if (mCnt[i] < validTime) mCnt[i] <= mCnt[i] + 1;
        else mQual[i] <= 1;
        good[i] = mQual[i] & (fNames(prioFirst, i) | fNames(prioSecond, i));
      end
      ns = mSel; nh = mHold;
      case (selMode)
        2'b00: begin
          nh = 0;
          if (pinCtrl) ns = selPin;
          else if (regSel == 2'b00) ns = 0;
          else if (regSel == 2'b01) ns = 1;
        end
        2'b01: begin
          nh = (good == 0);
          if (!good[mSel] && good[!mSel]) ns = !mSel;
        end
        2'b10: begin
          nh = (good == 0);
          if (prioFirst < 2 && good[prioFirst[0]]) ns = prioFirst[0];
          else if (prioSecond < 2 && good[prioSecond[0]]) ns = prioSecond[0];
        end
        default: ;
      endcase
      mSel <= ns; mHold <= nh;
    end
  end

  function automatic string modeTag(logic [1:0] m);
    case (m) 2'b00: return "R4"; 2'b01: return "R6"; 2'b10: return "R7"; default: return "R10"; endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d at %0t", tag, curTag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [1:0] expBad;
    for (int i = 0; i < 2; i++)
      expBad[i] = badPinEn[i] ? (badPol ? !mQual[i] : mQual[i]) : 1'b0; // R3 released pin reads pull-down
    chk(modeTag(selMode), int'(selIdx), int'(mSel));
    chk("R9", int'(holdFlag), int'(mHold));
    chk("R3", int'({badB, badA}), int'(expBad));
    chk("R11", int'({activePin, activeStat}),
        int'({actPol ? mSel : !mSel, mSel ? 2'b10 : 2'b01}));
  endtask

  task automatic run(int n, bit wiggle);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
      if (wiggle)
        for (int b = 0; b < 2; b++) begin
          if ($urandom % 14 == 0) losNormal[b] = !losNormal[b];
          if ($urandom % 14 == 0) losSlow[b] = !losSlow[b];
          if ($urandom % 20 == 0) fosAlarm[b] = !fosAlarm[b];
        end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    curTag = "R12"; run(1, 0);        // reset state
    rst_n = 1;
    curTag = "R2"; selMode = 2'b01; run(8, 0);
    fosAlarm[1] = 1; run(2, 0); fosAlarm[1] = 0; run(6, 0);
    curTag = "R1"; losEn1 = 2'b10; losNormal[0] = 1; run(6, 0);
    losSlow[0] = 1; run(3, 0); losSlow[0] = 0; losNormal[0] = 0;
    losEn2 = 2'b01; losNormal[1] = 1; losSlow[1] = 1; run(8, 0);
    losNormal[1] = 0; losSlow[1] = 0; losEn2 = 2'b11;
    curTag = "R8"; selMode = 2'b10; prioFirst = 2'b01; prioSecond = 2'b11; run(6, 0);
    fosAlarm[1] = 1; run(6, 0); fosAlarm[1] = 0; run(8, 0);
    curTag = "R5"; pinCtrl = 1;
    for (int k = 0; k < 6; k++) begin selPin = !selPin; run(2, 0); end
    selMode = 2'b00; for (int k = 0; k < 4; k++) begin selPin = !selPin; run(2, 0); end
    pinCtrl = 0; regSel = 2'b10; run(3, 0); regSel = 2'b00; run(3, 0);
    curTag = "R6"; selMode = 2'b01; prioFirst = 0; prioSecond = 1; regSel = 1; run(2, 0);
    fosAlarm[1] = 1; run(3, 0); fosAlarm[1] = 0; run(8, 0);
    curTag = "R7"; selMode = 2'b10; fosAlarm[0] = 1; run(3, 0); fosAlarm[0] = 0; run(8, 0);
    curTag = "R10"; selMode = 2'b11; fosAlarm = 2'b11; run(6, 0); fosAlarm = 0;
    curTag = "RND";
    for (int p = 0; p < 80; p++) begin
      selMode = 2'($urandom); prioFirst = 2'($urandom % 3); prioSecond = 2'($urandom);
      pinCtrl = 1'($urandom); selPin = 1'($urandom); regSel = 2'($urandom);
      validTime = VT_W'($urandom % 6); actPol = 1'($urandom); badPol = 1'($urandom);
      badPinEn = 2'($urandom); losEn1 = 2'($urandom); losEn2 = 2'($urandom);
      run(60, 1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(64'd20 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired (phase %s)", curTag);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule